// File: doc/BRIEF.md
# Single-Input-Change Test Pattern Generator

This block supplies stimulus vectors to a circuit under test while keeping the toggle rate at that circuit's inputs low. A binary counter runs through every one of its 2^W codes. The count is converted to reflected Gray code, and each Gray value is XORed with a seed word. Successive vectors therefore differ in a single bit for as long as the seed stays fixed.

The seed comes from a Fibonacci shift register. It moves to its next state only on the clock edge where the counter wraps from all ones back to zero. Each seed therefore covers one complete Gray walk of 2^W vectors before the next seed takes over. A load port lets the integrator start from a chosen seed. The enable input freezes the whole generator.

Top module: `sic_pattern_gen`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears the counter to zero and sets the seed to SEED_INIT (default 8'hA5). After reset, pattern equals SEED_INIT.
- R2: `pattern` equals seed XOR gray(count), where gray bit W-1 is count bit W-1 and gray bit i is count[i] XOR count[i+1]. The counter starts at zero and steps up by one on every enabled edge, in binary order.
- R3: While the seed stays unchanged, two consecutive enabled vectors differ in exactly one bit.
- R4: The seed changes only on an enabled edge where the counter goes from all ones to zero, or on a load. On that wrap it becomes {seed[W-2:0], ^(seed & TAP_MASK)}, with default TAP_MASK 8'hB8 (x^8+x^6+x^5+x^4+1).
- R5: With en low and seed_load low, the counter, the seed and pattern all keep their values.
- R6: With seed_load high, the next edge sets the seed to seed_value and clears the counter. This happens whatever the level of en, so pattern then equals the loaded seed.
- R7: A load whose seed_value is zero installs SEED_INIT instead, and still clears the counter.
- R8: The seed is never zero.
- R9: Across a wrap, the Hamming distance between the last and the first vector equals popcount(old_seed XOR gray(all ones) XOR new_seed).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the counter and the seed register |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable; when low, all state holds |
| seed_load | input | 1 | Load strobe for a new seed; also clears the counter |
| seed_value | input | W | Seed word to install; zero selects SEED_INIT |
| pattern | output | W | Test vector: seed XOR Gray code of the count |

## Verification
The hardest case to reach is a seed advance that coincides with other activity. The counter wraps only after 2^W enabled edges. A wrap is also easily lost when a load clears the counter or when en drops near the wrap. The stimulus therefore runs long unbroken enabled stretches that cross at least two wraps. It then mixes random enable gaps and random loads, zero loads among them. It also parks en low right at count all-ones, and the next enabled edge must then perform the seed step.

// File: rtl/sicg_pkg.sv
package sicg_pkg;
   typedef enum logic [1:0] {
      SEED_HOLD    = 2'd0,
      SEED_STEP    = 2'd1,
      SEED_LOAD    = 2'd2,
      SEED_DEFAULT = 2'd3
   } seed_cmd_e;
endpackage

// File: rtl/sicg_count.sv
module sicg_count #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         adv,
   input  logic         clear,
   output logic [W-1:0] count,
   output logic         wrap_next
);
   logic [W-1:0] count_q;
   logic [W-1:0] incr;

   assign incr = count_q + W'(1);

   // NOR of the incremented value: high only when the next count is zero
   assign wrap_next = ~|incr;

   always_ff @(posedge clk) begin
      if (rst)        count_q <= '0;
      else if (clear) count_q <= '0;
      else if (adv)   count_q <= incr;
   end

   assign count = count_q;
endmodule

// File: rtl/sicg_seed.sv
module sicg_seed
   import sicg_pkg::*;
#(
   parameter int           W         = 8,
   parameter logic [W-1:0] TAP_MASK  = 8'hB8,
   parameter logic [W-1:0] SEED_INIT = 8'hA5
) (
   input  logic         clk,
   input  logic         rst,
   input  seed_cmd_e    cmd,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] seed
);
   logic [W-1:0] seed_q;
   logic [W-1:0] stepped;
   logic [W-1:0] tapped;

   // feedback bits selected per tap position
   for (genvar i = 0; i < W; i++) begin : g_tap
      if (TAP_MASK[i]) begin : g_on
         assign tapped[i] = seed_q[i];
      end else begin : g_off
         assign tapped[i] = 1'b0;
      end
   end

   assign stepped = {seed_q[W-2:0], ^tapped};

   always_ff @(posedge clk) begin
      if (rst) begin
         seed_q <= SEED_INIT;
      end else begin
         unique case (cmd)
            SEED_STEP:    seed_q <= stepped;
            SEED_LOAD:    seed_q <= load_val;
            SEED_DEFAULT: seed_q <= SEED_INIT;
            default:      seed_q <= seed_q;
         endcase
      end
   end

   assign seed = seed_q;
endmodule

// File: rtl/sicg_mix.sv
module sicg_mix #(
   parameter int W = 8
) (
   input  logic [W-1:0] count,
   input  logic [W-1:0] seed,
   output logic [W-1:0] pattern
);
   logic [W-1:0] gray;

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (i == W - 1) begin : g_top
         assign gray[i] = count[i];
      end else begin : g_low
         assign gray[i] = count[i] ^ count[i+1];
      end
      assign pattern[i] = seed[i] ^ gray[i];
   end
endmodule

// File: rtl/sic_pattern_gen.sv
module sic_pattern_gen
   import sicg_pkg::*;
#(
   parameter int           W         = 8,
   parameter logic [W-1:0] TAP_MASK  = 8'hB8,
   parameter logic [W-1:0] SEED_INIT = 8'hA5
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   input  logic         seed_load,
   input  logic [W-1:0] seed_value,
   output logic [W-1:0] pattern
);
   if (W < 3) begin : g_bad_width
      $error("sic_pattern_gen: W must be at least 3");
   end
   if (TAP_MASK[W-1] != 1'b1) begin : g_bad_taps
      $error("sic_pattern_gen: TAP_MASK must include the top stage");
   end
   if (SEED_INIT == '0) begin : g_bad_init
      $error("sic_pattern_gen: SEED_INIT must be nonzero");
   end

   logic [W-1:0] count;
   logic [W-1:0] seed;
   logic         wrap_next;
   seed_cmd_e    cmd;

   always_comb begin
      if (seed_load)             cmd = (seed_value == '0) ? SEED_DEFAULT : SEED_LOAD;
      else if (en && wrap_next)  cmd = SEED_STEP;
      else                       cmd = SEED_HOLD;
   end

   sicg_count #(.W(W)) u_count (
      .clk       (clk),
      .rst       (rst),
      .adv       (en),
      .clear     (seed_load),
      .count     (count),
      .wrap_next (wrap_next)
   );

   sicg_seed #(.W(W), .TAP_MASK(TAP_MASK), .SEED_INIT(SEED_INIT)) u_seed (
      .clk      (clk),
      .rst      (rst),
      .cmd      (cmd),
      .load_val (seed_value),
      .seed     (seed)
   );

   sicg_mix #(.W(W)) u_mix (
      .count   (count),
      .seed    (seed),
      .pattern (pattern)
   );
endmodule

// File: rtl/sicg_checker.sv
module sicg_checker #(
   parameter int W = 8
) (
   input logic         clk,
   input logic         rst,
   input logic         en,
   input logic         seed_load,
   input logic [W-1:0] count,
   input logic [W-1:0] seed,
   input logic [W-1:0] pattern
);
   AST_ONE_BIT_STEP: assert property (@(posedge clk) disable iff (rst)
      (en && !seed_load && count != '1) |=> $countones(pattern ^ $past(pattern)) == 1); // R3

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!en && !seed_load) |=> ($stable(pattern) && $stable(count) && $stable(seed))); // R5

   AST_SEED_ONLY_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
      (!seed_load && !(en && count == '1)) |=> $stable(seed)); // R4

   AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (rst)
      seed_load |=> (count == '0 && pattern == seed)); // R6

   AST_SEED_NONZERO: assert property (@(posedge clk) disable iff (rst)
      seed != '0); // R8
endmodule

bind sic_pattern_gen sicg_checker #(.W(W)) u_sicg_checker (
   .clk       (clk),
   .rst       (rst),
   .en        (en),
   .seed_load (seed_load),
   .count     (count),
   .seed      (seed),
   .pattern   (pattern)
);

// File: tb/sim_sic_pattern_gen.sv
module sim_sic_pattern_gen;
   localparam int         W    = 8;
   localparam logic [7:0] INIT = 8'hA5;
   localparam logic [7:0] TAPS = 8'hB8;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         en = 1'b0;
   logic         seed_load = 1'b0;
   logic [W-1:0] seed_value = '0;
   logic [W-1:0] pattern;

   int total = 0;
   int bad = 0;
   bit done = 0;

   logic [W-1:0] m_cnt;
   logic [W-1:0] m_seed;
   logic [W-1:0] prev_pat;

   always #2 clk = ~clk;

   sic_pattern_gen u0 (
      .clk(clk), .rst(rst), .en(en), .seed_load(seed_load),
      .seed_value(seed_value), .pattern(pattern)
   );

   function automatic logic [W-1:0] to_gray(input logic [W-1:0] b);
      return b ^ (b >> 1);
   endfunction

   function automatic logic [W-1:0] lfsr_next(input logic [W-1:0] s);
      return {s[W-2:0], ^(s & TAPS)};
   endfunction

   task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one clock: drive at negedge, update model at edge, compare after it
   task automatic cyc(input bit e, input bit ld, input logic [W-1:0] v);
      logic [W-1:0] old_seed;
      logic [W-1:0] exp_pat;
      bit wrapped;
      @(negedge clk);
      en = e; seed_load = ld; seed_value = v;
      prev_pat = pattern;
      old_seed = m_seed;
      wrapped = 0;
      @(posedge clk);
      if (ld) begin
         m_seed = (v == '0) ? INIT : v;
         m_cnt = '0;
      end else if (e) begin
         if (m_cnt == '1) begin
            m_seed = lfsr_next(m_seed);
            wrapped = 1;
         end
         m_cnt = m_cnt + 1'b1;
      end
      #1;
      exp_pat = m_seed ^ to_gray(m_cnt);
      if (ld && v == '0)      check(pattern == exp_pat, "R7 zero load", pattern, exp_pat);
      else if (ld)            check(pattern == exp_pat, "R6 load", pattern, exp_pat);
      else if (!e)            check(pattern == prev_pat, "R5 hold", pattern, prev_pat);
      else if (wrapped)       check(pattern == exp_pat, "R4 seed step", pattern, exp_pat);
      else                    check(pattern == exp_pat, "R2 pattern", pattern, exp_pat);
      if (e && !ld && !wrapped)
         check($countones(pattern ^ prev_pat) == 1, "R3 one bit", pattern, prev_pat);
      if (wrapped)
         check($countones(pattern ^ prev_pat) ==
               $countones(old_seed ^ to_gray('1) ^ m_seed), "R9 wrap distance",
               W'($countones(pattern ^ prev_pat)),
               W'($countones(old_seed ^ to_gray('1) ^ m_seed)));
      check(m_seed != '0, "R8 seed nonzero", m_seed, m_seed);
   endtask

   initial begin
      int seed_rng;
      seed_rng = 1234;
      void'($urandom(seed_rng));
      repeat (2) @(posedge clk);
      #1;
      m_cnt = '0; m_seed = INIT;
      @(negedge clk);
      rst = 1'b0;
      check(pattern == INIT, "R1 reset", pattern, INIT);
      // directed: Gray table for low 3 bits at start of walk
      cyc(1, 0, '0);
      check(pattern == (INIT ^ 8'h01), "R2 count1", pattern, INIT ^ 8'h01);
      // long enabled run crossing two wraps
      for (int i = 0; i < 600; i++) cyc(1, 0, '0);
      // park with en low at all-ones, then resume
      while (m_cnt != '1) cyc(1, 0, '0);
      for (int i = 0; i < 5; i++) cyc(0, 0, '0);
      cyc(1, 0, '0);
      // load with en low, zero load
      cyc(0, 1, 8'h3C);
      check(pattern == 8'h3C, "R6 load with en low", pattern, 8'h3C);
      cyc(1, 1, 8'h00);
      check(pattern == INIT, "R7 zero load gives init", pattern, INIT);
      // random mix
      for (int i = 0; i < 2500; i++) begin
         int r;
         r = $urandom_range(0, 99);
         cyc(r < 80, r >= 98, W'($urandom_range(0, 255)));
      end
      // reset again mid-run
      @(negedge clk); rst = 1'b1;
      @(posedge clk); #1;
      m_cnt = '0; m_seed = INIT;
      @(negedge clk); rst = 1'b0;
      check(pattern == INIT, "R1 reset again", pattern, INIT);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%h expected=%h", 1'b0, 1'b1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule